// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block tells one local interrupt unit whether an interrupt message on the fabric is meant for it. Each message carries a shorthand code, a destination field and a bit that selects physical or logical addressing. The block compares these against the unit's own 8-bit identifier and its logical addressing state, and reports a single match bit. Matching among several targets and the delivery of the interrupt are left to other logic.

The block holds two pieces of state: a 32-bit logical destination word and a 32-bit format word. The format word chooses flat or cluster logical addressing. In extended mode, the format word plays no part. A logical match is then the bitwise AND of the whole logical word with the 32-bit destination. When extended mode is first entered, the block loads the logical word from the identifier. Both words can be read at the ports, and they can be written while extended mode is off.

Top module: `intr_dest_matcher`

## Requirements
- R1: Shorthand codes work as follows: 1 gives a match only when `src_is_local` is high; 2 always gives a match; 3 gives a match only when `src_is_local` is low. Code 0 uses the destination field.
- R2: With shorthand 0 and `dest_logical` low, `match` is high when `dest[7:0]` is 0xFF or equals `local_id`. `dest[31:8]` is ignored.
- R3: With shorthand 0, `dest_logical` high and extended mode off, a format nibble `fmt_q[31:28]` of 0xF selects flat addressing. `match` is then high when `ldr_q[31:24] & dest[7:0]` is nonzero.
- R4: Under the same conditions, a format nibble of 0x0 selects cluster addressing. `match` is then high only when `ldr_q[31:28]` equals `dest[7:4]` and `ldr_q[27:24] & dest[3:0]` is nonzero.
- R5: With extended mode off and any other format nibble, `fmt_invalid` is high and a logical message with shorthand 0 does not match.
- R6: With `ext_mode` high, a logical message with shorthand 0 matches when `ldr_q & dest` is nonzero. The format word is ignored, and `fmt_invalid` stays low.
- R7: In the cycle after `ext_mode` rises, `ldr_q` equals `{local_id[7:4], 20'b0} | (1 << local_id[3:0])`, placed in 32 bits. This takes priority over a write in that same cycle.
- R8: A write of the format word while `ext_mode` is low stores `wr_data | 0x0FFFFFFF`, visible from the next cycle. While `ext_mode` is high, the write is ignored.
- R9: A write of the logical word while `ext_mode` is low stores `wr_data & 0xFF000000`. While `ext_mode` is high, the write is ignored.
- R10: After reset, `ldr_q` is 0 and `fmt_q` is 0xFFFFFFFF (flat).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id | input | 8 | Identifier of this unit |
| ext_mode | input | 1 | Extended addressing mode enable |
| ldr_wr | input | 1 | Write strobe for the logical word |
| fmt_wr | input | 1 | Write strobe for the format word |
| wr_data | input | 32 | Write data for either word |
| src_is_local | input | 1 | The message was sent by this unit |
| shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| dest_logical | input | 1 | 1 logical, 0 physical addressing |
| dest | input | 32 | Destination field of the message |
| match | output | 1 | This unit is a target |
| fmt_invalid | output | 1 | Format nibble is neither flat nor cluster |
| ldr_q | output | 32 | Current logical word |
| fmt_q | output | 32 | Current format word |

## Verification
The assertions assume that `local_id` and the write strobes are stable around the clock edge. They also assume that extended mode stays on for the whole cycle after it is entered. The stimulus changes inputs only on the falling edge, and it holds `ext_mode` for runs of several cycles. The stimulus issues writes while extended mode is both on and off. Format writes use the flat, cluster and stray nibble values, and destinations are drawn to include the broadcast value, the local identifier and random words.

// File: rtl/dam_pkg.sv
package dam_pkg;
  localparam int ID_W      = 8;
  localparam int REG_W     = 32;
  localparam int NIB_W     = ID_W / 2;
  localparam int LID_LSB   = REG_W - ID_W;
  localparam int FMT_LSB   = REG_W - NIB_W;
  localparam int EXT_SHIFT = 16;

  typedef enum logic [1:0] {
    SH_NONE    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL_INC = 2'd2,
    SH_ALL_EXC = 2'd3
  } shorthand_e;

  typedef enum logic [NIB_W-1:0] {
    FMT_CLUSTER = 4'h0,
    FMT_FLAT    = 4'hF
  } fmt_e;

  // logical word derived on extended-mode entry
  function automatic logic [REG_W-1:0] ext_word(input logic [ID_W-1:0] id);
    logic [REG_W-1:0] r;
    logic [REG_W-1:0] hi;
    r = '0;
    r[id[NIB_W-1:0]] = 1'b1;
    hi = {{(REG_W-ID_W){1'b0}}, id[ID_W-1:NIB_W], {NIB_W{1'b0}}};
    return r | (hi << EXT_SHIFT);
  endfunction

  function automatic logic flat_hit(input logic [ID_W-1:0] lid,
                                    input logic [ID_W-1:0] mda);
    return |(lid & mda);
  endfunction

  function automatic logic cluster_hit(input logic [ID_W-1:0] lid,
                                       input logic [ID_W-1:0] mda);
    return (lid[ID_W-1:NIB_W] == mda[ID_W-1:NIB_W]) &&
           (|(lid[NIB_W-1:0] & mda[NIB_W-1:0]));
  endfunction

  function automatic logic [REG_W-1:0] fmt_fill(input logic [REG_W-1:0] d);
    return d | {{NIB_W{1'b0}}, {FMT_LSB{1'b1}}};
  endfunction

  function automatic logic [REG_W-1:0] ldr_keep(input logic [REG_W-1:0] d);
    return {d[REG_W-1:LID_LSB], {LID_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/dam_regs.sv
module dam_regs
  import dam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  local_id,
  input  logic             ext_mode,
  input  logic             ldr_wr,
  input  logic             fmt_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ldr_q,
  output logic [REG_W-1:0] fmt_q,
  output logic             ext_enter
);
  logic ext_q;

  assign ext_enter = ext_mode & ~ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      ldr_q <= '0;
      fmt_q <= '1;
    end else begin
      ext_q <= ext_mode;
      if (ext_enter)
        ldr_q <= ext_word(local_id);
      else if (ldr_wr && !ext_mode)
        ldr_q <= ldr_keep(wr_data);
      if (fmt_wr && !ext_mode)
        fmt_q <= fmt_fill(wr_data);
    end
  end

  p_fmt_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    &fmt_q[FMT_LSB-1:0]);
  p_ext_derive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_enter |=> ldr_q == ext_word($past(local_id)));
  p_ldr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !ext_enter && ldr_wr) |=> $stable(ldr_q));
  p_fmt_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && fmt_wr) |=> $stable(fmt_q));
endmodule

// File: rtl/dam_logical.sv
module dam_logical
  import dam_pkg::*;
(
  input  logic             ext_mode,
  input  logic [REG_W-1:0] ldr_q,
  input  logic [REG_W-1:0] fmt_q,
  input  logic [REG_W-1:0] dest,
  output logic             hit,
  output logic             fmt_bad
);
  logic [NIB_W-1:0] model;
  logic [ID_W-1:0]  lid;

  assign model = fmt_q[REG_W-1:FMT_LSB];
  assign lid   = ldr_q[REG_W-1:LID_LSB];

  always_comb begin
    fmt_bad = 1'b0;
    hit     = 1'b0;
    if (ext_mode) begin
      hit = |(ldr_q & dest);
    end else begin
      case (model)
        FMT_FLAT:    hit = flat_hit(lid, dest[ID_W-1:0]);
        FMT_CLUSTER: hit = cluster_hit(lid, dest[ID_W-1:0]);
        default:     fmt_bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/intr_dest_matcher.sv
module intr_dest_matcher
  import dam_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  local_id,
  input  logic        ext_mode,
  input  logic        ldr_wr,
  input  logic        fmt_wr,
  input  logic [31:0] wr_data,
  input  logic        src_is_local,
  input  logic [1:0]  shorthand,
  input  logic        dest_logical,
  input  logic [31:0] dest,
  output logic        match,
  output logic        fmt_invalid,
  output logic [31:0] ldr_q,
  output logic [31:0] fmt_q
);
  shorthand_e sh;
  logic       ext_enter;
  logic       log_hit;
  logic       phys_hit;
  logic       addr_hit;

  assign sh = shorthand_e'(shorthand);

  dam_regs u_regs (
    .clk(clk), .rst_n(rst_n), .local_id(local_id), .ext_mode(ext_mode),
    .ldr_wr(ldr_wr), .fmt_wr(fmt_wr), .wr_data(wr_data),
    .ldr_q(ldr_q), .fmt_q(fmt_q), .ext_enter(ext_enter)
  );

  dam_logical u_log (
    .ext_mode(ext_mode), .ldr_q(ldr_q), .fmt_q(fmt_q), .dest(dest),
    .hit(log_hit), .fmt_bad(fmt_invalid)
  );

  assign phys_hit = (dest[ID_W-1:0] == {ID_W{1'b1}}) || (dest[ID_W-1:0] == local_id);
  assign addr_hit = dest_logical ? log_hit : phys_hit;

  always_comb begin
    case (sh)
      SH_SELF:    match = src_is_local;
      SH_ALL_INC: match = 1'b1;
      SH_ALL_EXC: match = ~src_is_local;
      default:    match = addr_hit;
    endcase
  end

  p_all_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shorthand == 2'd2) |-> match);
  p_self_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shorthand == 2'd1) |-> (match == src_is_local));
  p_all_exc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shorthand == 2'd3) |-> (match != src_is_local));
  p_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shorthand == 2'd0 && !dest_logical && dest[7:0] == 8'hFF) |-> match);
  p_bad_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_invalid && shorthand == 2'd0 && dest_logical) |-> !match);
  p_ext_no_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !fmt_invalid);
endmodule

// File: tb/sim_intr_dest_matcher.sv
module sim_intr_dest_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  local_id = 8'h00;
  logic        ext_mode = 1'b0;
  logic        ldr_wr = 1'b0;
  logic        fmt_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        src_is_local = 1'b0;
  logic [1:0]  shorthand = 2'd0;
  logic        dest_logical = 1'b0;
  logic [31:0] dest = '0;
  logic        match, fmt_invalid;
  logic [31:0] ldr_q, fmt_q;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] m_ldr = 32'h0;
  logic [31:0] m_fmt = 32'hFFFF_FFFF;
  bit          m_ext_prev = 0;

  always #4 clk = ~clk;

  intr_dest_matcher u0 (
    .clk(clk), .rst_n(rst_n), .local_id(local_id), .ext_mode(ext_mode),
    .ldr_wr(ldr_wr), .fmt_wr(fmt_wr), .wr_data(wr_data),
    .src_is_local(src_is_local), .shorthand(shorthand),
    .dest_logical(dest_logical), .dest(dest), .match(match),
    .fmt_invalid(fmt_invalid), .ldr_q(ldr_q), .fmt_q(fmt_q)
  );

  // reference state model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ldr = 32'h0; m_fmt = 32'hFFFF_FFFF; m_ext_prev = 0;
    end else begin
      if (ext_mode && !m_ext_prev)
        m_ldr = (32'(local_id / 16) << 20) | (32'd1 << (local_id % 16));
      else if (ldr_wr && !ext_mode)
        m_ldr = wr_data & 32'hFF00_0000;
      if (fmt_wr && !ext_mode)
        m_fmt = wr_data | 32'h0FFF_FFFF;
      m_ext_prev = ext_mode;
    end
  end

  function automatic bit exp_bad();
    int model = int'(m_fmt >> 28);
    return !ext_mode && model != 15 && model != 0;
  endfunction

  function automatic bit exp_match();
    int lid = int'(m_ldr >> 24);
    int mda = int'(dest % 256);
    int model = int'(m_fmt >> 28);
    if (shorthand == 2'd1) return src_is_local;
    if (shorthand == 2'd2) return 1;
    if (shorthand == 2'd3) return !src_is_local;
    if (!dest_logical) return mda == 255 || mda == int'(local_id);
    if (ext_mode) return (m_ldr & dest) != 0;
    if (model == 15) return (lid & mda) != 0;
    if (model == 0) return (lid / 16 == mda / 16) && ((lid % 16) & (mda % 16)) != 0;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, 32'(match), 32'(exp_match()));
    chk(tag, 32'(fmt_invalid), 32'(exp_bad()));
    chk(tag, ldr_q, m_ldr);
    chk(tag, fmt_q, m_fmt);
    ldr_wr = 0; fmt_wr = 0;
  endtask

  task automatic msg(input logic [1:0] sh, input bit lg, input logic [31:0] d,
                     input bit self, input string tag);
    shorthand = sh; dest_logical = lg; dest = d; src_is_local = self;
    tick(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", ldr_q, 32'h0);
    chk("R10", fmt_q, 32'hFFFF_FFFF);
    rst_n = 1;
    local_id = 8'h3A;
    // R1 shorthands
    msg(2'd1, 0, 32'h0, 1, "R1"); msg(2'd1, 0, 32'h0, 0, "R1");
    msg(2'd2, 1, 32'h0, 0, "R1"); msg(2'd3, 0, 32'hFF, 1, "R1");
    msg(2'd3, 0, 32'h0, 0, "R1");
    // R2 physical
    msg(2'd0, 0, 32'h0000_00FF, 0, "R2"); msg(2'd0, 0, 32'h1234_563A, 0, "R2");
    msg(2'd0, 0, 32'h0000_003B, 0, "R2");
    // R9 logical word write, R3 flat
    ldr_wr = 1; wr_data = 32'h2C55_AAAA; tick("R9");
    msg(2'd0, 1, 32'h0000_0004, 0, "R3"); msg(2'd0, 1, 32'h0000_0013, 0, "R3");
    // R8 format write, R4 cluster
    fmt_wr = 1; wr_data = 32'h0123_4567; tick("R8");
    msg(2'd0, 1, 32'h0000_0024, 0, "R4"); msg(2'd0, 1, 32'h0000_0013, 0, "R4");
    msg(2'd0, 1, 32'h0000_0023, 0, "R4");
    // R5 stray format
    fmt_wr = 1; wr_data = 32'h5000_0000; tick("R5");
    msg(2'd0, 1, 32'h0000_00FF, 0, "R5"); msg(2'd1, 1, 32'h0, 1, "R5");
    // R7 entry with competing write, R6 extended matching
    ext_mode = 1; ldr_wr = 1; wr_data = 32'hFF00_0000; tick("R7");
    msg(2'd0, 1, 32'h0000_0400, 0, "R6"); msg(2'd0, 1, 32'h0030_0000, 0, "R6");
    msg(2'd0, 1, 32'h0000_0800, 0, "R6");
    ldr_wr = 1; fmt_wr = 1; wr_data = 32'h0F00_0000; tick("R9");
    ext_mode = 0; tick("R8");
    // randomized mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 4) ext_mode = ~ext_mode;
      if ($urandom_range(0, 9) == 0) local_id = 8'($urandom);
      ldr_wr = ($urandom_range(0, 7) == 0);
      fmt_wr = ($urandom_range(0, 7) == 0);
      wr_data = $urandom;
      case ($urandom_range(0, 2))
        0: wr_data[31:28] = 4'hF;
        1: wr_data[31:28] = 4'h0;
        default: ;
      endcase
      shorthand = 2'($urandom);
      if ($urandom_range(0, 1) == 0) shorthand = 2'd0;
      dest_logical = 1'($urandom);
      src_is_local = 1'($urandom);
      case ($urandom_range(0, 3))
        0: dest = 32'hFF;
        1: dest = {24'($urandom), local_id};
        2: dest = 32'($urandom_range(0, 255));
        default: dest = $urandom;
      endcase
      tick("R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule